// File: doc/BRIEF.md
# Branch Resolution and Next-PC Unit

This block chooses the next program counter for a simple 32-bit load/store processor. On every clock it looks at the current instruction word, the current PC and the two values read from the register file (operand A and operand B). It decides whether a branch is taken and where it goes. It also says whether the return address must be written to the link register, R15.

Two branch families are handled. The direct family adds a signed word offset from the instruction to the PC. The indirect family jumps to the full value of operand B. Either family can be taken when operand A is zero, taken when it is non-zero, or taken always. Either family can also save a return address. All results are registered, so they appear one clock after the inputs that produced them. The register file, the ALU and memory access are outside this block.

Top module: `brx_next_pc`

## Requirements
- R1: While `rst` is high at a clock edge, the next edge leaves `npc` equal to the parameter `RESET_PC` (default 0), with `link_en` at 0 and `link_val` at 0.
- R2: Outputs are registered. A change on any input first shows on the outputs after the next rising clock edge.
- R3: When `insn[31:28]` is neither 4 (direct branch) nor 5 (indirect branch), `npc` is `pc + 4` and `link_en` is 0, whatever the function bits and operands are.
- R4: When `insn[24]` (the zero condition) is set, the branch is taken if `ra_val` is 0.
- R5: When `insn[25]` (the non-zero condition) is set, the branch is taken if `ra_val` is not 0.
- R6: When both `insn[25:24]` bits are set, the branch is always taken. When both are clear, the branch is never taken.
- R7: A taken direct branch (opcode 4) sets `npc` to `pc` plus the sign-extended `insn[15:0]` shifted left by 2. The sum wraps modulo 2^32.
- R8: A taken indirect branch (opcode 5) sets `npc` to `rb_val` unchanged, including targets that are not word-aligned.
- R9: When a branch is taken and `insn[27]` (the link bit) is set, `link_en` is 1 and `link_val` is `pc + 4`. A branch that is not taken never asserts `link_en`, even when its link bit is set.
- R10: Whenever no branch is taken, `npc` is `pc + 4`, wrapping modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 32 | Current instruction word |
| pc | input | 32 | Current program counter |
| ra_val | input | 32 | Value read on register port A (condition operand) |
| rb_val | input | 32 | Value read on register port B (indirect target) |
| npc | output | 32 | Registered next program counter |
| link_en | output | 1 | Registered request to write R15 |
| link_val | output | 32 | Registered return address for R15 |

## Verification
Several stimuli set the link bit on a conditional branch whose condition fails. A design that linked regardless of the outcome would corrupt R15 there. Other stimuli use opcodes outside both branch families with both condition bits set, which catches a decoder that ignores the major opcode. Offsets of 0xFFFF and 0x8000 check sign extension and the two-bit shift. A target at the top of the address space checks wrap-around. An indirect target of 3 checks that the low bits are neither masked nor realigned. Function fields with no condition bits set must fall through, so a design that treated the empty field as "always" would be caught.

// File: rtl/brx_pkg.sv
package brx_pkg;
  localparam int OPC_W = 4;
  localparam logic [OPC_W-1:0] OPC_DIRECT   = 4'h4;
  localparam logic [OPC_W-1:0] OPC_INDIRECT = 4'h5;

  // function-field bit positions
  localparam int FN_ZERO = 0;
  localparam int FN_NZ   = 1;
  localparam int FN_LINK = 3;

  // next-PC selection, index is {indirect_taken, direct_taken}
  typedef enum logic [1:0] {
    SEL_SEQ   = 2'b00,
    SEL_REL   = 2'b01,
    SEL_REG   = 2'b10,
    SEL_REG_B = 2'b11
  } pc_sel_e;

  typedef struct packed {
    logic take_ind;
    logic take_dir;
    logic link;
  } brx_dec_t;
endpackage

// File: rtl/brx_decode.sv
module brx_decode
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [3:0]       fn,
  input  logic [XLEN-1:0]  ra_val,
  output brx_dec_t         dec
);
  logic a_zero;
  logic cond_ok;
  logic unused_fn2;

  assign a_zero     = (ra_val == '0);
  assign cond_ok    = (fn[FN_ZERO] & a_zero) | (fn[FN_NZ] & ~a_zero);
  assign unused_fn2 = fn[2];

  always_comb begin
    dec.take_dir = (opc == OPC_DIRECT)   & cond_ok;
    dec.take_ind = (opc == OPC_INDIRECT) & cond_ok;
    dec.link     = (dec.take_dir | dec.take_ind) & fn[FN_LINK];
  end
endmodule

// File: rtl/brx_target.sv
module brx_target #(
  parameter int XLEN  = 32,
  parameter int IMM_W = 16
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  seq_pc,
  output logic [XLEN-1:0]  rel_pc
);
  localparam int SHIFT = 2;
  localparam int EXT_W = XLEN - IMM_W - SHIFT;
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic [XLEN-1:0] offset;

  assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
  assign seq_pc = pc + STEP;
  assign rel_pc = pc + offset;
endmodule

// File: rtl/brx_pc_mux.sv
module brx_pc_mux
  import brx_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  pc_sel_e         sel,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] rel_pc,
  input  logic [XLEN-1:0] reg_pc,
  output logic [XLEN-1:0] nxt
);
  always_comb begin
    unique case (sel)
      SEL_SEQ:   nxt = seq_pc;
      SEL_REL:   nxt = rel_pc;
      SEL_REG:   nxt = reg_pc;
      SEL_REG_B: nxt = reg_pc;
      default:   nxt = seq_pc;
    endcase
  end
endmodule

// File: rtl/brx_next_pc.sv
module brx_next_pc
  import brx_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int IMM_W = 16,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [XLEN-1:0] insn,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] ra_val,
  input  logic [XLEN-1:0] rb_val,
  output logic [XLEN-1:0] npc,
  output logic            link_en,
  output logic [XLEN-1:0] link_val
);
  localparam int OPC_HI = XLEN - 1;
  localparam int FN_HI  = XLEN - OPC_W - 1;
  localparam int REG_LO = IMM_W;
  localparam int REG_HI = FN_HI - 4;

  brx_dec_t        dec;
  pc_sel_e         sel;
  logic [XLEN-1:0] seq_pc;
  logic [XLEN-1:0] rel_pc;
  logic [XLEN-1:0] nxt;
  logic            unused_regidx;

  // register index fields are resolved by the register file, not here
  assign unused_regidx = ^insn[REG_HI:REG_LO];

  brx_decode #(.XLEN(XLEN)) u_dec (
    .opc    (insn[OPC_HI -: OPC_W]),
    .fn     (insn[FN_HI -: 4]),
    .ra_val (ra_val),
    .dec    (dec)
  );

  brx_target #(.XLEN(XLEN), .IMM_W(IMM_W)) u_tgt (
    .pc     (pc),
    .imm    (insn[IMM_W-1:0]),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc)
  );

  assign sel = pc_sel_e'({dec.take_ind, dec.take_dir});

  brx_pc_mux #(.XLEN(XLEN)) u_mux (
    .sel    (sel),
    .seq_pc (seq_pc),
    .rel_pc (rel_pc),
    .reg_pc (rb_val),
    .nxt    (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      npc      <= RESET_PC;
      link_en  <= 1'b0;
      link_val <= '0;
    end else begin
      npc      <= nxt;
      link_en  <= dec.link;
      link_val <= dec.link ? seq_pc : '0;
    end
  end
endmodule

// File: rtl/brx_next_pc_chk.sv
module brx_next_pc_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] insn,
  input logic [XLEN-1:0] pc,
  input logic [XLEN-1:0] ra_val,
  input logic [XLEN-1:0] rb_val,
  input logic [XLEN-1:0] npc,
  input logic            link_en,
  input logic [XLEN-1:0] link_val
);
  logic past_ok;
  logic is_branch;
  logic cond_zero_hit;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign is_branch     = (insn[XLEN-1 -: 4] == 4'h4) || (insn[XLEN-1 -: 4] == 4'h5);
  assign cond_zero_hit = insn[XLEN-8] && (ra_val == '0);

  assert_non_branch_falls_through_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(is_branch)) |-> (npc == $past(pc) + 32'd4 && !link_en));

  assert_no_cond_never_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(insn[XLEN-7:XLEN-8] == 2'b00)) |-> (npc == $past(pc) + 32'd4 && !link_en));

  assert_indirect_target_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(insn[XLEN-1 -: 4] == 4'h5) && $past(cond_zero_hit)) |-> (npc == $past(rb_val)));

  assert_link_value_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && link_en) |-> (link_val == $past(pc) + 32'd4 && $past(insn[XLEN-5])));

  assert_link_taken_only_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && link_en) |-> (npc != $past(pc) + 32'd4 || $past(insn[15:0]) == 16'h0001
                              || $past(insn[XLEN-1 -: 4] == 4'h5)));
endmodule

bind brx_next_pc brx_next_pc_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_brx_next_pc.sv
module tb_brx_next_pc;
  localparam int N = 18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] insn = '0, pc = '0, ra_val = '0, rb_val = '0;
  logic [31:0] npc, link_val;
  logic        link_en;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  brx_next_pc dut (.clk(clk), .rst(rst), .insn(insn), .pc(pc), .ra_val(ra_val),
                   .rb_val(rb_val), .npc(npc), .link_en(link_en), .link_val(link_val));

  // insn, pc, ra, rb, expected npc, expected link_en, expected link_val, tag
  localparam logic [31:0] T_INSN [N] = '{
    32'h41000010, 32'h41000010, 32'h42000010, 32'h42000010, 32'h4300FFFF, 32'h4B008000,
    32'h49000001, 32'h51000000, 32'h52000000, 32'h53000000, 32'h5B000000, 32'h5A000000,
    32'h40000010, 32'h48000010, 32'h0F000000, 32'h6B000010, 32'h43000001, 32'h2B000000};
  localparam logic [31:0] T_PC [N] = '{
    32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'h00100000,
    32'h2000, 32'h3000, 32'h3000, 32'h3000, 32'h4000, 32'h4000,
    32'h1000, 32'h1000, 32'h1000, 32'h1000, 32'hFFFFFFFC, 32'hFFFFFFFC};
  localparam logic [31:0] T_RA [N] = '{
    32'h0, 32'h5, 32'h5, 32'h0, 32'h7, 32'h0,
    32'h3, 32'h0, 32'h0, 32'h9, 32'h0, 32'h1,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] T_RB [N] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
    32'h0, 32'h12345678, 32'hAAAA0000, 32'h00000003, 32'h80000000, 32'h55,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0] T_NPC [N] = '{
    32'h1040, 32'h1004, 32'h1040, 32'h1004, 32'h0FFC, 32'h000E0000,
    32'h2004, 32'h12345678, 32'h3004, 32'h00000003, 32'h80000000, 32'h55,
    32'h1004, 32'h1004, 32'h1004, 32'h1004, 32'h0, 32'h0};
  localparam logic T_LE [N] = '{
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [31:0] T_LV [N] = '{
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00100004,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h4004, 32'h4004,
    32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam string T_TAG [N] = '{
    "R4 R7", "R4 R10", "R5 R7", "R5 R10", "R6 R7", "R9 R7",
    "R9 not-taken", "R8 R4", "R5 R10", "R8 unaligned", "R9 R8", "R9 R5",
    "R6 none", "R6 R9", "R3", "R3", "R7 wrap", "R10 R3 wrap"};

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i, input logic [31:0] p,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    insn = i; pc = p; ra_val = a; rb_val = b;
    @(negedge clk);
  endtask

  initial begin
    #40000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check32("R1 npc", npc, 32'h0);
    check32("R1 link_en", {31'h0, link_en}, 32'h0);
    check32("R1 link_val", link_val, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int k = 0; k < N; k++) begin
      apply(T_INSN[k], T_PC[k], T_RA[k], T_RB[k]);
      check32({T_TAG[k], " npc"}, npc, T_NPC[k]);
      check32({T_TAG[k], " link_en"}, {31'h0, link_en}, {31'h0, T_LE[k]});
      if (T_LE[k]) check32({T_TAG[k], " link_val"}, link_val, T_LV[k]);
    end

    // R2: outputs hold until the next rising edge
    apply(32'h5B000000, 32'h7000, 32'h0, 32'hCAFE0000);
    @(negedge clk);
    insn = 32'h00000000; pc = 32'h9000;
    #1;
    check32("R2 npc held", npc, 32'hCAFE0000);
    check32("R2 link_en held", {31'h0, link_en}, 32'h1);
    @(negedge clk);
    check32("R2 npc updated", npc, 32'h9004);

    // R1: reset mid-run overrides a taken linking branch
    @(negedge clk);
    insn = 32'h4B000010; pc = 32'h5000; rst = 1'b1;
    @(negedge clk);
    check32("R1 mid npc", npc, 32'h0);
    check32("R1 mid link_en", {31'h0, link_en}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    check32("R9 after reset", link_val, 32'h5004);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule